// File: doc/BRIEF.md
# Bit and Byte Reversal Permutation Unit

This unit applies one of a small set of fixed bit permutations to a word. The permutations are the ones cryptographic code needs. It can reverse the bits inside every byte, and it can reverse the order of the bytes across the whole word. In the 32-bit build it can also interleave the two halfwords bit by bit, or split an interleaved word back into its halves. The general reverse and shuffle operations with arbitrary control values are not offered. Only these fixed instances exist.

The width is the parameter `XLEN`, which is either 32 or 64. A datapath presents an operand together with an operation code and a valid strobe. One clock later the unit returns the permuted word, a valid strobe and an illegal flag. The illegal flag rises for an operation code that the current build does not support, and the result is then zero. The latency is always one cycle and never depends on the data.

Top module: `bperm_unit`

## Requirements
- R1: Operation code 0 (byte bit reverse) reverses the order of the eight bits inside each byte and leaves every byte at its position. For example, 32'h01020304 gives 32'h8040C020.
- R2: Operation code 1 (byte order reverse) reverses the order of the bytes across the full XLEN-bit word. For example, 32'h11223344 gives 32'h44332211, and 64'h0102030405060708 gives 64'h0807060504030201.
- R3: With XLEN=32, operation code 2 (interleave) puts source bit i at result bit 2i and source bit 16+i at result bit 2i+1, for i from 0 to 15.
- R4: With XLEN=32, operation code 3 (de-interleave) is the exact inverse of the R3 mapping. Source bit 2i goes to result bit i, and source bit 2i+1 goes to result bit 16+i.
- R5: With XLEN=64, operation codes 2 and 3 are rejected: illegal_o is 1 and result_o is 0.
- R6: Operation codes 4 to 7 are rejected at any XLEN.
- R7: Any rejected operation sets illegal_o to 1 and result_o to 0. A legal operation sets illegal_o to 0.
- R8: When valid_i is sampled high at a rising clock edge, valid_o is 1 after that edge and carries the result of that input. When valid_i is sampled low, valid_o is 0 after the edge.
- R9: While valid_i is low, result_o and illegal_o keep their last values, whatever src_i and op_i do.
- R10: While rst_ni is low, valid_o, result_o and illegal_o are all 0.
- R11: Applying byte order reverse twice, applying byte bit reverse twice, or applying interleave and then de-interleave returns the original operand.
- R12: A legal operation leaves the number of set bits in the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operand valid |
| op_i | input | 3 | Operation code: 0 byte bit reverse, 1 byte order reverse, 2 interleave, 3 de-interleave |
| src_i | input | XLEN | Source operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | XLEN | Registered permuted word |
| illegal_o | output | 1 | Registered flag for an unsupported operation |

## Verification
Each byte in the byte bit reverse vectors has a distinct value, so a bit swapped within a byte is caught, and so is a byte moved to another position. Byte order reverse uses patterns whose bytes differ, and a single-byte pattern shows which end of the word each byte lands at. Interleave and de-interleave use all-ones halfwords and single set bits, which show whether the lower and upper halfwords have been swapped between the even and odd result bits. A 64-bit instance is also exercised. Random round trips catch permutations that are not inverses of each other, and rejected codes together with idle cycles show the zero result and the held output.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  localparam int unsigned OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_BREV8 = 3'd0,
    OP_REV8  = 3'd1,
    OP_ZIP   = 3'd2,
    OP_UNZIP = 3'd3
  } bperm_op_e;
endpackage

// File: rtl/bperm_brev8.sv
module bperm_brev8 #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] dst_o
);
  localparam int unsigned NB = XLEN / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign dst_o[8*b+k] = src_i[8*b+7-k];
    end
  end
endmodule

// File: rtl/bperm_rev8.sv
module bperm_rev8 #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] dst_o
);
  localparam int unsigned NB = XLEN / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dst_o[8*b +: 8] = src_i[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/bperm_zip.sv
module bperm_zip #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] zip_o,
  output logic [XLEN-1:0] unzip_o
);
  localparam int unsigned HALF = XLEN / 2;
  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign zip_o[2*i]        = src_i[i];
    assign zip_o[2*i+1]      = src_i[HALF+i];
    assign unzip_o[i]        = src_i[2*i];
    assign unzip_o[HALF+i]   = src_i[2*i+1];
  end
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
  import bperm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [XLEN-1:0]     src_i,
  output logic                valid_o,
  output logic [XLEN-1:0]     result_o,
  output logic                illegal_o
);
  localparam bit HAS_ZIP = (XLEN == 32);

  logic [XLEN-1:0] brev_w, rev_w, zip_w, unzip_w;
  logic [XLEN-1:0] res_d;
  logic            ill_d;

  bperm_brev8 #(.XLEN(XLEN)) u_brev (.src_i(src_i), .dst_o(brev_w));
  bperm_rev8  #(.XLEN(XLEN)) u_rev  (.src_i(src_i), .dst_o(rev_w));

  if (HAS_ZIP) begin : g_zip
    bperm_zip #(.XLEN(XLEN)) u_zip (
      .src_i   (src_i),
      .zip_o   (zip_w),
      .unzip_o (unzip_w)
    );
  end else begin : g_nozip
    assign zip_w   = '0;
    assign unzip_w = '0;
  end

  always_comb begin
    res_d = '0;
    ill_d = 1'b0;
    case (bperm_op_e'(op_i))
      OP_BREV8: res_d = brev_w;
      OP_REV8:  res_d = rev_w;
      OP_ZIP: begin
        res_d = zip_w;
        ill_d = !HAS_ZIP;
      end
      OP_UNZIP: begin
        res_d = unzip_w;
        ill_d = !HAS_ZIP;
      end
      default:  ill_d = 1'b1;
    endcase
    if (ill_d) res_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        illegal_o <= ill_d;
      end
    end
  end
endmodule

// File: rtl/bperm_unit_chk.sv
module bperm_unit_chk
  import bperm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] src_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  logic op_legal;
  assign op_legal = (op_i < 3'd2) || ((XLEN == 32) && (op_i < 3'd4));

  assert_valid_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o)));
  assert_illegal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));
  assert_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_legal) |=> illegal_o);
  assert_popcount_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_legal) |=> (!illegal_o && ($countones(result_o) == $countones($past(src_i)))));
endmodule

bind bperm_unit bperm_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bperm_unit_tb.sv
`timescale 1ns/1ps
module bperm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v32 = 1'b0, v64 = 1'b0;
  logic [2:0]  op32 = '0, op64 = '0;
  logic [31:0] s32 = '0;
  logic [63:0] s64 = '0;
  logic        vo32, vo64, il32, il64;
  logic [31:0] r32;
  logic [63:0] r64;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  bperm_unit #(.XLEN(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v32), .op_i(op32), .src_i(s32),
    .valid_o(vo32), .result_o(r32), .illegal_o(il32));

  bperm_unit #(.XLEN(64)) u_dut64 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v64), .op_i(op64), .src_i(s64),
    .valid_o(vo64), .result_o(r64), .illegal_o(il64));

  // {op, src, expected}; ops 4..7 expect illegal and zero
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h01020304, 32'h8040C020},  // R1
    {3'd0, 32'h0F0F0F0F, 32'hF0F0F0F0},  // R1
    {3'd1, 32'h11223344, 32'h44332211},  // R2
    {3'd1, 32'h000000FF, 32'hFF000000},  // R2
    {3'd2, 32'h0000FFFF, 32'h55555555},  // R3
    {3'd2, 32'hFFFF0000, 32'hAAAAAAAA},  // R3
    {3'd2, 32'h00010000, 32'h00000002},  // R3
    {3'd2, 32'h00000001, 32'h00000001},  // R3
    {3'd3, 32'h55555555, 32'h0000FFFF},  // R4
    {3'd3, 32'hAAAAAAAA, 32'hFFFF0000},  // R4
    {3'd5, 32'hFFFFFFFF, 32'h00000000},  // R6
    {3'd7, 32'h12345678, 32'h00000000}   // R6
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] src);
    @(negedge clk);
    v32 = 1'b1; op32 = op; s32 = src;
    @(negedge clk);
    v32 = 1'b0;
  endtask

  task automatic run64(input logic [2:0] op, input logic [63:0] src);
    @(negedge clk);
    v64 = 1'b1; op64 = op; s64 = src;
    @(negedge clk);
    v64 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    logic [31:0] hold_r;
    logic        hold_i;
    repeat (3) @(negedge clk);
    chk("R10 valid_o", {63'd0, vo32}, 64'd0);
    chk("R10 result_o", {32'd0, r32}, 64'd0);
    chk("R10 illegal_o", {63'd0, il32}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run32(VEC[i][66:64], VEC[i][63:32]);
      chk($sformatf("R8 valid vec%0d", i), {63'd0, vo32}, 64'd1);
      chk($sformatf("R1-4/R7 result vec%0d", i), {32'd0, r32}, {32'd0, VEC[i][31:0]});
      chk($sformatf("R7 illegal vec%0d", i), {63'd0, il32}, {63'd0, VEC[i][66:64] >= 3'd4});
    end

    // R9: idle cycles with changing inputs keep the output
    hold_r = r32; hold_i = il32;
    @(negedge clk);
    s32 = 32'hDEADBEEF; op32 = 3'd1;
    @(negedge clk);
    chk("R8 valid low", {63'd0, vo32}, 64'd0);
    chk("R9 result held", {32'd0, r32}, {32'd0, hold_r});
    chk("R9 illegal held", {63'd0, il32}, {63'd0, hold_i});

    // R11: round trips with varied operands
    for (int k = 0; k < 8; k++) begin
      x = 32'h9E3779B9 * (k + 1) ^ (32'h1F << k);
      run32(3'd1, x); y = r32; run32(3'd1, y);
      chk("R11 rev8 twice", {32'd0, r32}, {32'd0, x});
      run32(3'd0, x); y = r32; run32(3'd0, y);
      chk("R11 brev8 twice", {32'd0, r32}, {32'd0, x});
      run32(3'd2, x); y = r32; run32(3'd3, y);
      chk("R11 zip unzip", {32'd0, r32}, {32'd0, x});
      chk("R12 popcount zip", 64'($countones(y)), 64'($countones(x)));
    end

    // 64-bit build
    run64(3'd1, 64'h0102030405060708);
    chk("R2 rev8 64", r64, 64'h0807060504030201);
    chk("R8 valid 64", {63'd0, vo64}, 64'd1);
    run64(3'd0, 64'h0102030405060708);
    chk("R1 brev8 64", r64, 64'h8040C020A060E010);
    run64(3'd2, 64'hFFFFFFFF0000FFFF);
    chk("R5 zip 64 result", r64, 64'd0);
    chk("R5 zip 64 flag", {63'd0, il64}, 64'd1);
    run64(3'd1, 64'hAABBCCDDEEFF0011);
    chk("R7 legal clears flag", {63'd0, il64}, 64'd0);
    run64(3'd3, 64'h5555555555555555);
    chk("R5 unzip 64 flag", {63'd0, il64}, 64'd1);
    chk("R5 unzip 64 result", r64, 64'd0);
    run64(3'd6, 64'hFFFFFFFFFFFFFFFF);
    chk("R6 code 6 on 64", {63'd0, il64}, 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule